// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This block is a purely combinational unit for the execute stage of a classic 32-bit RISC pipeline. From one instruction's fields (major opcode, function code and the selector held in the rt field), together with the two register operands and the 16-bit immediate, it decides whether a compare-based conditional branch is taken and whether a conditional trap fires.

It covers three encoding groups:
- register-form traps under the zero major opcode;
- the register-immediate group, which holds zero-compare branches, their linking and likely variants, and immediate traps;
- the primary-opcode branches and their likely variants.

Signed and unsigned orderings are kept apart.

Beside the taken and trap results it reports three more flags:
- a link-write flag for the linking branches;
- an annul flag that tells the pipeline to squash the delay slot of a likely branch that falls through;
- an invalid-encoding flag for unassigned selectors inside its groups.

Instructions outside these groups produce all-zero outputs.

Top module: `brc_cond_eval`

## Requirements
- R1: With major opcode 0, function codes 0x30, 0x31, 0x32, 0x33, 0x34 and 0x36 raise the trap flag when rs >= rt signed, rs >= rt unsigned, rs < rt signed, rs < rt unsigned, rs == rt and rs != rt respectively. The taken, link and annul flags stay low.
- R2: With major opcode 0, function codes 0x35 and 0x37 assert only the invalid flag. Every other function code under opcode 0 yields all outputs low.
- R3: With major opcode 1, rt selector 0 branches when rs < 0 (signed) and selector 1 when rs >= 0. Selectors 2 and 3 are the same two compares in likely form. The rt register value never affects these results.
- R4: Selectors 16, 17, 18 and 19 are the linking forms of selectors 0, 1, 2 and 3, in that order. The link flag is high for them whether or not the branch is taken.
- R5: Selectors 8, 9, 10, 11, 12 and 14 are immediate traps with the compare order of R1, applied to rs and the sign-extended immediate. The sign extension applies to the unsigned compares as well.
- R6: Major opcodes 4 and 5 branch when rs == rt and rs != rt. Opcodes 6 and 7 branch when rs <= 0 and rs > 0 (signed), and rt has no effect on them.
- R7: Major opcodes 20, 21, 22 and 23 are the likely forms of opcodes 4, 5, 6 and 7, with the same compares.
- R8: The annul flag is high only for a likely-form branch whose condition is false. It is never high together with the taken flag.
- R9: Every opcode-1 selector not listed in R3, R4 or R5 asserts only the invalid flag.
- R10: Every major opcode other than 0, 1, 4-7 and 20-23 yields all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_opcode | input | 6 | Major opcode field |
| i_funct | input | 6 | Function code field (opcode 0 group) |
| i_rt_sel | input | 5 | rt field, used as selector in the opcode 1 group |
| i_rs_val | input | 32 | Value of register rs |
| i_rt_val | input | 32 | Value of register rt |
| i_imm | input | 16 | Immediate field |
| o_taken | output | 1 | Branch condition met |
| o_trap | output | 1 | Trap condition met |
| o_link | output | 1 | Branch writes the return address |
| o_annul | output | 1 | Likely branch not taken; squash delay slot |
| o_invalid | output | 1 | Unassigned encoding inside a handled group |

## Verification
The embedded assertions hold on every input combination:
- a branch and a trap never fire together;
- an invalid encoding raises no other flag;
- annul excludes taken;
- link appears only in the opcode-1 group;
- the comparator's equal, signed-less and unsigned-less results stay mutually consistent.

Only the bench scenarios can show that each selector maps to the right compare. They also cover operands that differ only in the sign bit, where signed and unsigned orderings disagree, and immediates with bit 15 set against unsigned traps. A behavioural reference model is compared with the outputs over directed corner values and a long random sweep.

// File: rtl/brc_pkg.sv
package brc_pkg;

   localparam logic [5:0] OPC_SPECIAL = 6'd0;
   localparam logic [5:0] OPC_REGIMM  = 6'd1;

   typedef enum logic [2:0] {
      K_GE_S = 3'd0,
      K_GE_U = 3'd1,
      K_LT_S = 3'd2,
      K_LT_U = 3'd3,
      K_EQ   = 3'd4,
      K_NE   = 3'd5,
      K_LE_S = 3'd6,
      K_GT_S = 3'd7
   } cmp_kind_e;

   typedef enum logic [1:0] {
      B_RT   = 2'd0,
      B_IMM  = 2'd1,
      B_ZERO = 2'd2
   } bsrc_e;

   typedef struct packed {
      cmp_kind_e kind;
      bsrc_e     bsrc;
      logic      is_branch;
      logic      is_trap;
      logic      is_link;
      logic      is_likely;
      logic      invalid;
   } dec_t;

   // Maps the low three selector bits of a trap group to its compare.
   function automatic cmp_kind_e trap_kind(input logic [2:0] s);
      case (s)
         3'd0:    trap_kind = K_GE_S;
         3'd1:    trap_kind = K_GE_U;
         3'd2:    trap_kind = K_LT_S;
         3'd3:    trap_kind = K_LT_U;
         3'd4:    trap_kind = K_EQ;
         default: trap_kind = K_NE;
      endcase
   endfunction

endpackage

// File: rtl/brc_decode.sv
module brc_decode
   import brc_pkg::*;
(
   input  logic [5:0] i_opcode,
   input  logic [5:0] i_funct,
   input  logic [4:0] i_rt_sel,
   output dec_t       o_dec
);

   always_comb begin
      o_dec = '{kind: K_EQ, bsrc: B_RT, default: 1'b0};
      case (i_opcode)
         OPC_SPECIAL: begin
            if (i_funct[5:3] == 3'b110) begin
               if (i_funct[2:0] == 3'd5 || i_funct[2:0] == 3'd7) begin
                  o_dec.invalid = 1'b1;
               end else begin
                  o_dec.is_trap = 1'b1;
                  o_dec.kind    = trap_kind(i_funct[2:0]);
                  o_dec.bsrc    = B_RT;
               end
            end
         end
         OPC_REGIMM: begin
            case (i_rt_sel)
               5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17, 5'd18, 5'd19: begin
                  o_dec.is_branch = 1'b1;
                  o_dec.bsrc      = B_ZERO;
                  o_dec.kind      = i_rt_sel[0] ? K_GE_S : K_LT_S;
                  o_dec.is_likely = i_rt_sel[1];
                  o_dec.is_link   = i_rt_sel[4];
               end
               5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd14: begin
                  o_dec.is_trap = 1'b1;
                  o_dec.bsrc    = B_IMM;
                  o_dec.kind    = trap_kind(i_rt_sel[2:0]);
               end
               default: o_dec.invalid = 1'b1;
            endcase
         end
         6'd4, 6'd5, 6'd6, 6'd7, 6'd20, 6'd21, 6'd22, 6'd23: begin
            o_dec.is_branch = 1'b1;
            o_dec.is_likely = i_opcode[4];
            case (i_opcode[1:0])
               2'd0:    begin o_dec.kind = K_EQ;   o_dec.bsrc = B_RT;   end
               2'd1:    begin o_dec.kind = K_NE;   o_dec.bsrc = B_RT;   end
               2'd2:    begin o_dec.kind = K_LE_S; o_dec.bsrc = B_ZERO; end
               default: begin o_dec.kind = K_GT_S; o_dec.bsrc = B_ZERO; end
            endcase
         end
         default: ;
      endcase
   end

   // R1 R5: a decoded instruction is never both a branch and a trap
   always_comb begin
      p_one_class_r1: assert ($onehot0({o_dec.is_branch, o_dec.is_trap, o_dec.invalid}));
   end

endmodule

// File: rtl/brc_compare.sv
module brc_compare #(
   parameter int XLEN     = 32,
   parameter int CMP_IMPL = 0   // 0: one shared subtractor, 1: separate operators
) (
   input  logic [XLEN-1:0] i_a,
   input  logic [XLEN-1:0] i_b,
   output logic            o_eq,
   output logic            o_lt_s,
   output logic            o_lt_u
);

   localparam int MSB = XLEN - 1;

   generate
      if (XLEN < 2) begin : g_bad_width
         $error("brc_compare: XLEN must be at least 2");
      end
      if (CMP_IMPL == 0) begin : g_sub
         logic [XLEN:0] diff;
         assign diff   = {1'b0, i_a} - {1'b0, i_b};
         assign o_eq   = (diff[MSB:0] == '0);
         assign o_lt_u = diff[XLEN];
         assign o_lt_s = (i_a[MSB] ^ i_b[MSB]) ? i_a[MSB] : diff[XLEN];
      end else if (CMP_IMPL == 1) begin : g_ops
         assign o_eq   = (i_a == i_b);
         assign o_lt_u = (i_a < i_b);
         assign o_lt_s = ($signed(i_a) < $signed(i_b));
      end else begin : g_bad_impl
         $error("brc_compare: CMP_IMPL must be 0 or 1");
      end
   endgenerate

   // R1: equality excludes both orderings; same sign bits make orderings agree
   always_comb begin
      if (o_eq) p_eq_not_less_r1: assert (!o_lt_s && !o_lt_u);
      if (i_a[MSB] == i_b[MSB]) p_sign_agree_r1: assert (o_lt_s == o_lt_u);
   end

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
   import brc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int IMM_W    = 16,
   parameter int CMP_IMPL = 0
) (
   input  logic [5:0]       i_opcode,
   input  logic [5:0]       i_funct,
   input  logic [4:0]       i_rt_sel,
   input  logic [XLEN-1:0]  i_rs_val,
   input  logic [XLEN-1:0]  i_rt_val,
   input  logic [IMM_W-1:0] i_imm,
   output logic             o_taken,
   output logic             o_trap,
   output logic             o_link,
   output logic             o_annul,
   output logic             o_invalid
);

   localparam int EXT_W = XLEN - IMM_W;

   generate
      if (IMM_W < 1 || EXT_W < 1) begin : g_bad_imm
         $error("brc_cond_eval: IMM_W must be at least 1 and below XLEN");
      end
   endgenerate

   dec_t            dec;
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] opnd_b;
   logic            eq, lt_s, lt_u;
   logic            cond;

   brc_decode u_dec (
      .i_opcode (i_opcode),
      .i_funct  (i_funct),
      .i_rt_sel (i_rt_sel),
      .o_dec    (dec)
   );

   assign imm_ext = {{EXT_W{i_imm[IMM_W-1]}}, i_imm};

   always_comb begin
      case (dec.bsrc)
         B_RT:    opnd_b = i_rt_val;
         B_IMM:   opnd_b = imm_ext;
         default: opnd_b = '0;
      endcase
   end

   brc_compare #(.XLEN(XLEN), .CMP_IMPL(CMP_IMPL)) u_cmp (
      .i_a    (i_rs_val),
      .i_b    (opnd_b),
      .o_eq   (eq),
      .o_lt_s (lt_s),
      .o_lt_u (lt_u)
   );

   always_comb begin
      case (dec.kind)
         K_GE_S:  cond = !lt_s;
         K_GE_U:  cond = !lt_u;
         K_LT_S:  cond = lt_s;
         K_LT_U:  cond = lt_u;
         K_EQ:    cond = eq;
         K_NE:    cond = !eq;
         K_LE_S:  cond = lt_s || eq;
         default: cond = !(lt_s || eq);
      endcase
   end

   assign o_taken   = dec.is_branch && cond;
   assign o_trap    = dec.is_trap && cond;
   assign o_link    = dec.is_link;
   assign o_annul   = dec.is_likely && !cond;
   assign o_invalid = dec.invalid;

   always_comb begin
      if (o_invalid) p_inv_quiet_r9: assert (!(o_taken || o_trap || o_link || o_annul));
      if (o_annul) p_annul_excl_r8: assert (!o_taken && !o_trap);
      if (o_link) p_link_group_r4: assert (i_opcode == OPC_REGIMM);
      p_br_trap_excl_r1: assert (!(o_taken && o_trap));
   end

endmodule

// File: tb/sim_brc_cond_eval.sv
module sim_brc_cond_eval;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  opc = '0;
   logic [5:0]  fn = '0;
   logic [4:0]  rts = '0;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic [15:0] imm = '0;
   logic        tk, tp, lk, an, iv;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   brc_cond_eval u0 (
      .i_opcode(opc), .i_funct(fn), .i_rt_sel(rts),
      .i_rs_val(a), .i_rt_val(b), .i_imm(imm),
      .o_taken(tk), .o_trap(tp), .o_link(lk), .o_annul(an), .o_invalid(iv)
   );

   function automatic bit tcmp(input int s, input logic [31:0] x, input logic [31:0] y);
      longint sx = longint'($signed(x));
      longint sy = longint'($signed(y));
      longint ux = longint'({32'd0, x});
      longint uy = longint'({32'd0, y});
      case (s)
         0: return sx >= sy;
         1: return ux >= uy;
         2: return sx < sy;
         3: return ux < uy;
         4: return x == y;
         default: return x != y;
      endcase
   endfunction

   // expected {taken, trap, link, annul, invalid}
   function automatic logic [4:0] model(input logic [5:0] o, input logic [5:0] f,
                                        input logic [4:0] r, input logic [31:0] x,
                                        input logic [31:0] y, input logic [15:0] im,
                                        output string tag);
      longint sx = longint'($signed(x));
      logic [31:0] ie = {{16{im[15]}}, im};
      bit c;
      tag = "R10";
      if (o == 6'd0) begin
         tag = "R2";
         if (f == 6'h35 || f == 6'h37) return 5'b00001;
         if (f >= 6'h30 && f <= 6'h36) begin
            tag = "R1";
            return {1'b0, tcmp(int'(f - 6'h30), x, y), 3'b000};
         end
         return 5'b0;
      end
      if (o == 6'd1) begin
         if (r <= 5'd3 || (r >= 5'd16 && r <= 5'd19)) begin
            tag = (r >= 5'd16) ? "R4" : "R3";
            c = (r % 2 == 0) ? (sx < 0) : (sx >= 0);
            return {c, 1'b0, r >= 5'd16, ((r % 4) >= 2) && !c, 1'b0};
         end
         if ((r >= 5'd8 && r <= 5'd12) || r == 5'd14) begin
            tag = "R5";
            return {1'b0, tcmp(int'(r - 5'd8), x, ie), 3'b000};
         end
         tag = "R9";
         return 5'b00001;
      end
      if ((o >= 6'd4 && o <= 6'd7) || (o >= 6'd20 && o <= 6'd23)) begin
         tag = (o >= 6'd20) ? "R7" : "R6";
         case (o % 4)
            0: c = (x == y);
            1: c = (x != y);
            2: c = (sx <= 0);
            default: c = (sx > 0);
         endcase
         return {c, 1'b0, 1'b0, (o >= 6'd20) && !c, 1'b0};
      end
      return 5'b0;
   endfunction

   task automatic apply(input logic [5:0] o, input logic [5:0] f, input logic [4:0] r,
                        input logic [31:0] x, input logic [31:0] y, input logic [15:0] im,
                        input string note);
      logic [4:0] exp, act;
      string tag;
      @(posedge clk);
      #1;
      opc = o; fn = f; rts = r; a = x; b = y; imm = im;
      @(negedge clk);
      exp = model(o, f, r, x, y, im, tag);
      act = {tk, tp, lk, an, iv};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s op=%0d fn=%h rt=%0d a=%h b=%h imm=%h actual=%b expected=%b",
                  tag, note, o, f, r, x, y, im, act, exp);
      end
      // R8: annul never with taken
      checks++;
      if (an && tk) begin
         fails++;
         $display("FAIL R8 annul with taken actual=%b expected=0", an);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero instruction gives all-zero outputs (R2)
      apply(6'd0, 6'd0, 5'd0, 32'd0, 32'd0, 16'd0, "reset state R2");
      // R1: sign bit differs, signed and unsigned disagree
      for (int f = 6'h30; f <= 6'h37; f++) begin
         apply(6'd0, 6'(f), 5'd0, 32'h8000_0000, 32'h0000_0001, 16'd0, "R1 sign split");
         apply(6'd0, 6'(f), 5'd0, 32'h0000_0005, 32'h0000_0005, 16'd0, "R1 equal");
         apply(6'd0, 6'(f), 5'd0, 32'h0000_0001, 32'hFFFF_FFFF, 16'd0, "R1 neg rt");
      end
      apply(6'd0, 6'h20, 5'd0, 32'd1, 32'd1, 16'd0, "R2 other funct");
      // R3 R4: zero compares, rt value irrelevant
      for (int r = 0; r < 32; r++) begin
         apply(6'd1, 6'd0, 5'(r), 32'h0, 32'hFFFF_FFFF, 16'h8000, "R3/R4/R5/R9 zero");
         apply(6'd1, 6'd0, 5'(r), 32'hFFFF_FFFF, 32'h0, 16'hFFFF, "R3/R4/R5/R9 neg");
         apply(6'd1, 6'd0, 5'(r), 32'h7FFF_FFFF, 32'h8000_0000, 16'h7FFF, "R3/R4/R5/R9 pos");
      end
      // R5: unsigned immediate trap with negative immediate -> 0xFFFF8000
      apply(6'd1, 6'd0, 5'd11, 32'h0001_0000, 32'd0, 16'h8000, "R5 tltiu sext");
      apply(6'd1, 6'd0, 5'd9,  32'hFFFF_8000, 32'd0, 16'h8000, "R5 tgeiu sext eq");
      // R6 R7
      for (int o = 0; o < 64; o++) begin
         apply(6'(o), 6'h30, 5'd1, 32'd0, 32'd0, 16'd0, "R6/R7/R10 zero");
         apply(6'(o), 6'h31, 5'd17, 32'h8000_0000, 32'h8000_0000, 16'd1, "R6/R7/R10 min");
         apply(6'(o), 6'h00, 5'd2, 32'd3, 32'hFFFF_FFF0, 16'd1, "R6/R7/R10 pos");
      end
      // random sweep
      for (int i = 0; i < 3000; i++) begin
         logic [5:0] o;
         logic [31:0] x, y;
         o = (i % 3 == 0) ? 6'd1 : ((i % 3 == 1) ? 6'd0 : 6'($urandom_range(0, 23)));
         x = $urandom;
         y = (i % 5 == 0) ? x : $urandom;
         if (i % 7 == 0) x = {16'hFFFF, 16'($urandom)};
         apply(o, 6'($urandom_range(40, 63)), 5'($urandom), x, y, 16'($urandom), "random");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule